// File: doc/BRIEF.md
# Folded Word Memory with Column Selection

This block is a synchronous single-port memory of 2048 words by 16 bits. Its storage is not a flat array of words. It is a physical array of 256 rows, each 128 bits wide, so each row holds eight words. Each access splits the word address into two parts. The upper part picks one row through a one-hot row select. The lower part picks one 16-bit slice of that row through sixteen 8:1 column selectors, one for each data bit.

A write reads the selected row, replaces only the 16 columns named by the column index, and stores the row again. A read registers the selected row and the column index. The column selectors then drive the output, so data appears one clock after the address is sampled. A parameter chooses how the words are laid out in a row. The default interleaves the bits of the eight words, so that the eight inputs of each column selector sit in adjacent physical columns. The other layout places each word in a contiguous run of 16 columns.

Top module: `fsram_folded`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0. Reset does not alter the stored words: a word written before reset reads back unchanged after it.
- R2: `addr[10:3]` is the row index (256 rows of 128 bits) and `addr[2:0]` is the slot within the row. Addresses that differ only in their low three bits are distinct words of the same row.
- R3: The word at the address sampled on a rising edge is on `rdata` after that edge and stays there until the next edge. Back-to-back reads of different addresses each return their own word in consecutive cycles.
- R4: With `we` = 1 on a rising edge, `wdata` is stored at `addr`, and any later read of that address returns it.
- R5: A write changes only the 16 columns of the selected slot. The other seven words of the row and every other row keep their values.
- R6: Exactly one row is selected for every access while out of reset.
- R7: In a write cycle, `rdata` returns the content the addressed word held before the write (read-first).
- R8: For any sequence of reads and writes, every read returns what a flat 2048 x 16 memory would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| addr | input | 11 | Word address: row index in the upper 8 bits, slot in the lower 3 |
| we | input | 1 | Write enable for the current cycle |
| wdata | input | 16 | Word to store when `we` is 1 |
| rdata | output | 16 | Word read at the address sampled on the previous edge |

## Verification
The bench writes a distinct word to every address and reads all of them back. This catches a swapped or shifted address split, and a mapping from bits to columns that differs between the write path and the read path: either fault makes words alias or come back scrambled. Targeted writes into one row are followed by reads of its seven neighbour slots and the adjacent rows. A merge that clears or overwrites the whole row, or a row select that fires two rows, shows up as corrupted neighbours. A write cycle's own output is checked for the old value, which exposes a write-first bypass. Alternating reads expose an extra or missing pipeline stage. A long pseudo-random run, biased towards a few rows, compares every read against a flat word array.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

   // Physical column of bit 'bit_i' of word slot 'slot' inside one row.
   // interleave = 1: the eight slots of one data bit sit side by side.
   // interleave = 0: each word occupies a contiguous run of columns.
   function automatic int phys_col(input int bit_i, input int slot,
                                   input int word_w, input int fold,
                                   input bit interleave);
      return interleave ? (bit_i * fold + slot) : (slot * word_w + bit_i);
   endfunction

endpackage

// File: rtl/fsram_row_dec.sv
module fsram_row_dec #(
   parameter int ROW_W = 8,
   localparam int ROWS = 1 << ROW_W
) (
   input  logic [ROW_W-1:0] row_idx,
   output logic [ROWS-1:0]  wordline
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign wordline[r] = (row_idx == ROW_W'(r));
   end

endmodule

// File: rtl/fsram_col_mux.sv
module fsram_col_mux #(
   parameter int WORD_W     = 16,
   parameter int SEL_W      = 3,
   parameter bit INTERLEAVE = 1'b1,
   localparam int FOLD      = 1 << SEL_W,
   localparam int ROW_BITS  = WORD_W * FOLD
) (
   input  logic [ROW_BITS-1:0] row_data,
   input  logic [SEL_W-1:0]    sel,
   output logic [WORD_W-1:0]   word
);

   for (genvar j = 0; j < WORD_W; j++) begin : g_bit
      logic [FOLD-1:0] group;
      for (genvar c = 0; c < FOLD; c++) begin : g_in
         if (INTERLEAVE) begin : g_il
            assign group[c] = row_data[j*FOLD + c];
         end else begin : g_ct
            assign group[c] = row_data[c*WORD_W + j];
         end
      end
      assign word[j] = group[sel];
   end

endmodule

// File: rtl/fsram_row_merge.sv
module fsram_row_merge #(
   parameter int WORD_W     = 16,
   parameter int SEL_W      = 3,
   parameter bit INTERLEAVE = 1'b1,
   localparam int FOLD      = 1 << SEL_W,
   localparam int ROW_BITS  = WORD_W * FOLD
) (
   input  logic [ROW_BITS-1:0] old_row,
   input  logic [SEL_W-1:0]    sel,
   input  logic [WORD_W-1:0]   wdata,
   output logic [ROW_BITS-1:0] new_row
);

   for (genvar c = 0; c < FOLD; c++) begin : g_slot
      logic hit;
      assign hit = (sel == SEL_W'(c));
      for (genvar j = 0; j < WORD_W; j++) begin : g_bit
         localparam int IDX = INTERLEAVE ? (j*FOLD + c) : (c*WORD_W + j);
         assign new_row[IDX] = hit ? wdata[j] : old_row[IDX];
      end
   end

endmodule

// File: rtl/fsram_folded.sv
module fsram_folded #(
   parameter int WORD_W     = 16,
   parameter int ADDR_W     = 11,
   parameter int COL_SEL_W  = 3,
   parameter bit INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   import fsram_pkg::*;

   localparam int ROW_W    = ADDR_W - COL_SEL_W;
   localparam int ROWS     = 1 << ROW_W;
   localparam int FOLD     = 1 << COL_SEL_W;
   localparam int ROW_BITS = WORD_W * FOLD;

   // elaboration-time parameter checks
   if (COL_SEL_W < 1 || COL_SEL_W >= ADDR_W) begin : g_bad_split
      $error("fsram_folded: COL_SEL_W must lie in 1..ADDR_W-1");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("fsram_folded: WORD_W must be positive");
   end

   logic [ROW_BITS-1:0]  mem [ROWS];
   logic [ROW_W-1:0]     row_idx;
   logic [COL_SEL_W-1:0] col_idx;
   logic [ROWS-1:0]      wordline;
   logic [ROW_BITS-1:0]  cur_row;
   logic [ROW_BITS-1:0]  new_row;
   logic [ROW_BITS-1:0]  rd_row_q;
   logic [COL_SEL_W-1:0] col_q;

   assign row_idx = addr[ADDR_W-1:COL_SEL_W];
   assign col_idx = addr[COL_SEL_W-1:0];
   assign cur_row = mem[row_idx];

   fsram_row_dec #(.ROW_W(ROW_W)) i_row_dec (
      .row_idx  (row_idx),
      .wordline (wordline)
   );

   fsram_row_merge #(
      .WORD_W(WORD_W), .SEL_W(COL_SEL_W), .INTERLEAVE(INTERLEAVE)
   ) i_row_merge (
      .old_row (cur_row),
      .sel     (col_idx),
      .wdata   (wdata),
      .new_row (new_row)
   );

   always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS; r++) begin
         if (we && wordline[r]) mem[r] <= new_row;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_row_q <= '0;
         col_q    <= '0;
      end else begin
         rd_row_q <= cur_row;
         col_q    <= col_idx;
      end
   end

   fsram_col_mux #(
      .WORD_W(WORD_W), .SEL_W(COL_SEL_W), .INTERLEAVE(INTERLEAVE)
   ) i_col_mux (
      .row_data (rd_row_q),
      .sel      (col_q),
      .word     (rdata)
   );

   // ---------------- assertions ----------------
   function automatic logic [WORD_W-1:0] slice_of(input logic [ROW_BITS-1:0] rb,
                                                  input logic [COL_SEL_W-1:0] c);
      logic [WORD_W-1:0] s;
      for (int j = 0; j < WORD_W; j++)
         s[j] = rb[phys_col(j, int'(c), WORD_W, FOLD, INTERLEAVE)];
      return s;
   endfunction

   logic                 chk_valid_q;
   logic [ROW_W-1:0]     chk_row_q;
   logic [COL_SEL_W-1:0] chk_col_q;
   logic [WORD_W-1:0]    chk_data_q;
   logic [ROW_BITS-1:0]  chk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_valid_q <= 1'b0;
      else        chk_valid_q <= we;
   end

   always_ff @(posedge clk) begin
      chk_row_q  <= row_idx;
      chk_col_q  <= col_idx;
      chk_data_q <= wdata;
      chk_prev_q <= cur_row;
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (rdata == '0));

   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_q |-> (slice_of(mem[chk_row_q], chk_col_q) == chk_data_q));

   a_r5_slice_only: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_q && !$isunknown(chk_prev_q))
         |-> ($countones(mem[chk_row_q] ^ chk_prev_q) <= WORD_W));

   a_r6_one_row: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(wordline));

endmodule

// File: tb/test_fsram_folded.sv
module test_fsram_folded;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] addr = '0;
   logic        we = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;

   logic [15:0] ref_mem [2048];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   fsram_folded i_fsram_folded (
      .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
   );

   function automatic logic [15:0] pat(input int a);
      return 16'(a * 40503) ^ 16'h3C3C;
   endfunction

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic access(input int a, input logic w, input logic [15:0] d,
                         input bit chk, input string tag);
      logic [15:0] expv;
      expv  = ref_mem[a];
      addr  = 11'(a);
      we    = w;
      wdata = d;
      @(posedge clk);
      if (w) ref_mem[a] = d;
      @(negedge clk);
      we = 1'b0;
      if (chk) check(rdata, expv, tag);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(rdata, 16'h0000, "R1 reset value");
      rst_n = 1'b1;
   endtask

   task automatic t_fill_and_read;
      for (int a = 0; a < 2048; a++) access(a, 1'b1, pat(a), 1'b0, "");
      for (int a = 0; a < 2048; a++) access(a, 1'b0, '0, 1'b1, "R2 R8 full readback");
   endtask

   task automatic t_split;
      access(0,    1'b1, 16'hFFFF, 1'b0, "");
      access(1,    1'b1, 16'h0001, 1'b0, "");
      access(8,    1'b1, 16'h8000, 1'b0, "");
      access(2047, 1'b1, 16'hA5A5, 1'b0, "");
      access(2040, 1'b1, 16'h0000, 1'b0, "");
      access(0,    1'b0, '0, 1'b1, "R2 addr 0");
      access(1,    1'b0, '0, 1'b1, "R2 slot bit");
      access(8,    1'b0, '0, 1'b1, "R2 row bit");
      access(2047, 1'b0, '0, 1'b1, "R2 top addr");
      access(2040, 1'b0, '0, 1'b1, "R2 top row slot 0");
   endtask

   task automatic t_neighbours;
      access(32'h55*8 + 3, 1'b1, 16'hFFFF, 1'b0, "");
      access(32'h55*8 + 6, 1'b1, 16'h0000, 1'b0, "");
      for (int a = 32'h54*8; a < 32'h57*8; a++)
         access(a, 1'b0, '0, 1'b1, "R4 R5 R6 row neighbours");
   endtask

   task automatic t_read_first;
      access(300, 1'b1, 16'h1234, 1'b1, "R7 write cycle shows old");
      access(300, 1'b1, 16'hBEEF, 1'b1, "R7 second write shows first");
      access(300, 1'b0, '0, 1'b1, "R4 read after write");
   endtask

   task automatic t_latency;
      for (int i = 0; i < 8; i++) begin
         access(i[0] ? 1500 : 77, 1'b0, '0, 1'b1, "R3 back-to-back reads");
      end
      addr = 11'd900;
      @(posedge clk);
      @(negedge clk);
      check(rdata, ref_mem[900], "R3 data after edge");
      @(posedge clk);
      #2;
      check(rdata, ref_mem[900], "R3 held to next edge");
      @(negedge clk);
   endtask

   task automatic t_reset_keeps;
      rst_n = 1'b0;
      @(negedge clk);
      check(rdata, 16'h0000, "R1 mid-run reset");
      rst_n = 1'b1;
      access(300, 1'b0, '0, 1'b0, "");
      access(2047, 1'b0, '0, 1'b1, "R1 contents survive reset");
      access(300,  1'b0, '0, 1'b1, "R1 contents survive reset");
   endtask

   task automatic t_random;
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         int a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr[0] ? {lfsr[9:8], 3'b000} | int'(lfsr[6:4]) : int'(lfsr[15:5]);
         access(a, lfsr[1] & lfsr[2], {lfsr[7:0], lfsr[15:8]}, 1'b1, "R8 random vs flat");
      end
   endtask

   initial begin
      t_reset();
      t_fill_and_read();
      t_split();
      t_neighbours();
      t_read_first();
      t_latency();
      t_reset_keeps();
      t_random();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule